// File: doc/BRIEF.md
# Synthesizer Reference Divider, Phase Detector and Lock Logic

This block is the digital heart of a tuner frequency synthesizer. A reference divider, clocked by the crystal clock, produces one comparison pulse per period. Its ratio can be chosen from three values. On the feedback side, a fixed prescaler and a programmable divider count enable ticks from the VCO path. A dual flip-flop phase/frequency detector compares the two pulse trains. It drives up and down requests to an external charge pump.

A lock detector measures the one-sided width of each comparison. It declares lock after a run of clean comparisons. The lock state drives three things: an active-high lock flag, an active-low lock indication on a shared pin, and the charge-pump current level. When automatic switching is enabled, the current drops to the low level once lock is held. Test selects reroute the shared pin to show the reference pulse train or the divided feedback at half rate. The charge pump, the loop amplifier and the oscillator are outside the block.

Top module: `pll_synth_core`

## Requirements
- R1: `ref_sel` picks the reference ratio: 00 selects REF_A, 01 selects REF_B, 10 and 11 select REF_C. The reference produces one single-cycle pulse per ratio cycles of `clk`. With `test_sel` = 01 that pulse appears on `test_out`.
- R2: The feedback divider produces one terminal count per PRESCALE times N cycles in which `vco_tick` is high, where N is `div_val`. With `test_sel` = 10, `test_out` toggles once per terminal count.
- R3: With `test_sel` = 00 or 11, `test_out` is the inverse of `lock_flag`, so it is low while locked. `lock_flag` is 1 while locked.
- R4: Lock is set after LOCK_CNT consecutive comparisons whose one-sided width is at most LOCK_WIN cycles. Matched reference and feedback periods lock. Mismatched periods never lock.
- R5: `cp_hi` follows `cp_hi_req`, except that it is 0 while `auto_en` is 1 and the loop is locked. `auto_active` is 1 exactly in that forced state.
- R6: `pump_up` asserts when the reference pulse leads. `pump_dn` asserts when the feedback pulse leads. The two are never both high on two consecutive cycles.
- R7: A change of `div_val` or `ref_sel` clears the lock within 3 cycles. The new values are loaded at the next terminal count of each divider, and a matched new setting locks again.
- R8: A `div_val` of 0 or 1 divides as 2.
- R9: While `rst` is high, `pump_up`, `pump_dn`, `lock_flag`, `cp_hi` and `auto_active` are 0, and `test_out` is 1.
- R10: Lock clears as soon as a one-sided width grows past LOCK_WIN cycles, for example when the feedback ticks stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock driving the whole block |
| rst | input | 1 | Synchronous active-high reset |
| vco_tick | input | 1 | One-cycle enable per VCO-path edge, counted by the prescaler |
| ref_sel | input | 2 | Reference ratio select |
| div_val | input | DIV_W | Programmable feedback divide value |
| cp_hi_req | input | 1 | Requested charge-pump level, 1 = high current |
| auto_en | input | 1 | Enables automatic drop to low current when locked |
| test_sel | input | 2 | Shared-pin select: 00/11 lock, 01 reference, 10 half feedback |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| cp_hi | output | 1 | Applied charge-pump level, 1 = high |
| auto_active | output | 1 | Automatic low-current override in force |
| lock_flag | output | 1 | Active-high lock status |
| test_out | output | 1 | Shared pin: active-low lock or test signal |

## Verification
The bench builds the block with reference ratios 16, 20 and 32, a prescaler of 2, a lock run of 4 and a window of 2 cycles. With these values, lock is reached in about a hundred cycles. Matched and mismatched divide values become small integers. A 160-cycle window holds an exact whole number of reference periods for every ratio. The small prescaler also makes the clamped ratio of 2 give a four-cycle feedback period, and pulses of that period can be counted exactly on the test pin.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;
  typedef enum logic [1:0] {
    TSEL_LOCK  = 2'b00,
    TSEL_REF   = 2'b01,
    TSEL_FBH   = 2'b10,
    TSEL_LOCKB = 2'b11
  } tsel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
  parameter int REF_A = 512,
  parameter int REF_B = 640,
  parameter int REF_C = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ref_sel,
  output logic       ref_pulse
);
  localparam int RMAX = pll_core_pkg::max3(REF_A, REF_B, REF_C);
  localparam int CW   = $clog2(RMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] ratio;

  always_comb begin
    unique case (ref_sel)
      2'b00:   ratio = CW'(REF_A);
      2'b01:   ratio = CW'(REF_B);
      default: ratio = CW'(REF_C);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= ratio - 1'b1;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= (cnt == '0);
      if (cnt == '0) cnt <= ratio - 1'b1;
      else           cnt <= cnt - 1'b1;
    end
  end

  AST_REF_PULSE_SPACED: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse); // R1
endmodule

// File: rtl/pll_fb_div.sv
module pll_fb_div #(
  parameter int PRESCALE = 8,
  parameter int DIV_W    = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vco_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             fb_pulse
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0]    pre_cnt;
  logic             pre_pulse;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] n_eff;

  assign n_eff     = (div_val < DIV_W'(2)) ? DIV_W'(2) : div_val;
  assign pre_pulse = vco_tick && (pre_cnt == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else if (vco_tick) begin
      if (pre_cnt == PW'(PRESCALE - 1)) pre_cnt <= '0;
      else                              pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= n_eff - 1'b1;
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= pre_pulse && (cnt == '0);
      if (pre_pulse) begin
        if (cnt == '0) cnt <= n_eff - 1'b1;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  AST_FB_PULSE_SPACED: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse); // R8
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic up,
  output logic dn
);
  logic both;
  assign both = up && dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (both) begin
      up <= ref_pulse;
      dn <= fb_pulse;
    end else begin
      up <= up | ref_pulse;
      dn <= dn | fb_pulse;
    end
  end

  AST_PFD_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> !(up && dn)); // R6
  AST_UP_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    $rose(up) |-> $past(ref_pulse)); // R6
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int LOCK_CNT = 4,
  parameter int LOCK_WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic up,
  input  logic dn,
  output logic locked
);
  localparam int EW = $clog2(LOCK_WIN + 2);
  localparam int GW = $clog2(LOCK_CNT + 1);

  logic [EW-1:0] err;
  logic [GW-1:0] good;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err    <= '0;
      good   <= '0;
      locked <= 1'b0;
    end else if (up && dn) begin
      err <= '0;
      if (err <= EW'(LOCK_WIN)) begin
        if (good >= GW'(LOCK_CNT - 1)) begin
          good   <= GW'(LOCK_CNT);
          locked <= 1'b1;
        end else begin
          good <= good + 1'b1;
        end
      end else begin
        good   <= '0;
        locked <= 1'b0;
      end
    end else if (up ^ dn) begin
      if (err != EW'(LOCK_WIN + 1)) err <= err + 1'b1;
      if (err >= EW'(LOCK_WIN)) begin
        good   <= '0;
        locked <= 1'b0;
      end
    end
  end

  AST_LOCK_AFTER_COMPARE: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(up && dn)); // R4
  AST_CLEAR_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    clr |=> !locked); // R7
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core #(
  parameter int REF_A    = 512,
  parameter int REF_B    = 640,
  parameter int REF_C    = 1024,
  parameter int PRESCALE = 8,
  parameter int DIV_W    = 15,
  parameter int LOCK_CNT = 4,
  parameter int LOCK_WIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vco_tick,
  input  logic [1:0]       ref_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cp_hi_req,
  input  logic             auto_en,
  input  logic [1:0]       test_sel,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             cp_hi,
  output logic             auto_active,
  output logic             lock_flag,
  output logic             test_out
);
  import pll_core_pkg::*;

  logic             ref_pulse, fb_pulse, locked, cfg_chg, fb_half;
  logic [1:0]       prev_sel;
  logic [DIV_W-1:0] prev_div;

  pll_ref_div #(.REF_A(REF_A), .REF_B(REF_B), .REF_C(REF_C)) u_ref (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .ref_pulse(ref_pulse));

  pll_fb_div #(.PRESCALE(PRESCALE), .DIV_W(DIV_W)) u_fb (
    .clk(clk), .rst(rst), .vco_tick(vco_tick), .div_val(div_val),
    .fb_pulse(fb_pulse));

  pll_pfd u_pfd (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .up(pump_up), .dn(pump_dn));

  pll_lock_det #(.LOCK_CNT(LOCK_CNT), .LOCK_WIN(LOCK_WIN)) u_lock (
    .clk(clk), .rst(rst), .clr(cfg_chg), .up(pump_up), .dn(pump_dn),
    .locked(locked));

  assign cfg_chg = (ref_sel != prev_sel) || (div_val != prev_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sel    <= ref_sel;
      prev_div    <= div_val;
      fb_half     <= 1'b0;
      cp_hi       <= 1'b0;
      auto_active <= 1'b0;
      lock_flag   <= 1'b0;
      test_out    <= 1'b1;
    end else begin
      prev_sel    <= ref_sel;
      prev_div    <= div_val;
      if (fb_pulse) fb_half <= ~fb_half;
      auto_active <= auto_en && locked;
      cp_hi       <= cp_hi_req && !(auto_en && locked);
      lock_flag   <= locked;
      unique case (tsel_e'(test_sel))
        TSEL_REF: test_out <= ref_pulse;
        TSEL_FBH: test_out <= fb_half ^ fb_pulse;
        default:  test_out <= ~locked;
      endcase
    end
  end

  AST_AUTO_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    auto_active |-> !cp_hi); // R5
  AST_LOCK_PIN_POLARITY: assert property (@(posedge clk) disable iff (rst)
    ($past(test_sel) == 2'b00 || $past(test_sel) == 2'b11)
      |-> (test_out != lock_flag)); // R3
endmodule

// File: tb/test_pll_synth_core.sv
module test_pll_synth_core;
  localparam int RA = 16, RB = 20, RC = 32, PS = 2, DW = 15;

  logic clk = 0, rst = 1, vco_tick = 1, cp_hi_req = 0, auto_en = 0;
  logic [1:0] ref_sel = 0, test_sel = 0;
  logic [DW-1:0] div_val = 8;
  logic pump_up, pump_dn, cp_hi, auto_active, lock_flag, test_out;

  int checks = 0, failures = 0;
  int n_rise, n_chg, n_uponly, n_dnonly, n_overlap = 0;
  logic prev_t = 1, prev_both = 0;

  localparam logic [17:0] VEC [8] = '{
    {2'b00, 15'd8,  1'b1}, {2'b01, 15'd10, 1'b1},
    {2'b10, 15'd16, 1'b1}, {2'b11, 15'd16, 1'b1},
    {2'b00, 15'd9,  1'b0}, {2'b00, 15'd7,  1'b0},
    {2'b10, 15'd17, 1'b0}, {2'b01, 15'd11, 1'b0}};

  pll_synth_core #(.REF_A(RA), .REF_B(RB), .REF_C(RC), .PRESCALE(PS),
    .DIV_W(DW), .LOCK_CNT(4), .LOCK_WIN(2)) i_pll_synth_core (
    .clk(clk), .rst(rst), .vco_tick(vco_tick), .ref_sel(ref_sel),
    .div_val(div_val), .cp_hi_req(cp_hi_req), .auto_en(auto_en),
    .test_sel(test_sel), .pump_up(pump_up), .pump_dn(pump_dn),
    .cp_hi(cp_hi), .auto_active(auto_active), .lock_flag(lock_flag),
    .test_out(test_out));

  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (test_out != prev_t) n_chg++;
      if (test_out && !prev_t) n_rise++;
      prev_t = test_out;
      if (pump_up && !pump_dn) n_uponly++;
      if (pump_dn && !pump_up) n_dnonly++;
      if (pump_up && pump_dn && prev_both) n_overlap++;
      prev_both = pump_up && pump_dn;
    end
  endtask

  task automatic clr_mon();
    n_rise = 0; n_chg = 0; n_uponly = 0; n_dnonly = 0;
    prev_t = test_out;
  endtask

  task automatic do_reset(input logic [1:0] s, input int d);
    ref_sel = s; div_val = DW'(d); vco_tick = 1; rst = 1;
    run(4);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9 reset state
    cp_hi_req = 1;
    do_reset(2'b00, 8);
    rst = 1; run(1);
    chk(!pump_up && !pump_dn, "R9 pumps idle", {pump_up, pump_dn}, 0);
    chk(!lock_flag && test_out, "R9 lock flag/pin", {lock_flag, test_out}, 1);
    chk(!cp_hi && !auto_active, "R9 current outputs", {cp_hi, auto_active}, 0);
    rst = 0;

    // R4 / R3 table walk
    for (int k = 0; k < 8; k++) begin
      test_sel = (k == 3) ? 2'b11 : 2'b00;
      do_reset(VEC[k][17:16], int'(VEC[k][15:1]));
      run(330);
      chk(lock_flag == VEC[k][0], $sformatf("R4 lock vec %0d", k), lock_flag, VEC[k][0]);
      chk(test_out == !VEC[k][0], $sformatf("R3 lock pin vec %0d", k), test_out, !VEC[k][0]);
    end

    // R1 reference rate on test pin
    test_sel = 2'b01;
    for (int s = 0; s < 4; s++) begin
      automatic int r = (s == 0) ? RA : (s == 1) ? RB : RC;
      do_reset(2'(s), r / PS);
      run(70); clr_mon(); run(160);
      chk(n_rise == 160 / r, $sformatf("R1 ref pulses sel %0d", s), n_rise, 160 / r);
    end

    // R2 feedback at half rate, R8 clamp
    test_sel = 2'b10;
    do_reset(2'b00, 5); run(40); clr_mon(); run(160);
    chk(n_chg == 16, "R2 fb toggles div 5", n_chg, 16);
    do_reset(2'b00, 12); run(60); clr_mon(); run(240);
    chk(n_chg == 10, "R2 fb toggles div 12", n_chg, 10);
    do_reset(2'b00, 0); run(20); clr_mon(); run(160);
    chk(n_chg == 40, "R8 clamp div 0", n_chg, 40);
    do_reset(2'b00, 1); run(20); clr_mon(); run(160);
    chk(n_chg == 40, "R8 clamp div 1", n_chg, 40);

    // R6 lead direction
    test_sel = 2'b00;
    do_reset(2'b00, 9); clr_mon(); run(256);
    chk(n_uponly > 0 && n_dnonly == 0, "R6 ref leads", n_dnonly, 0);
    do_reset(2'b00, 7); clr_mon(); run(256);
    chk(n_dnonly > 0 && n_uponly == 0, "R6 fb leads", n_uponly, 0);

    // R5 automatic current switch
    cp_hi_req = 1; auto_en = 0;
    do_reset(2'b00, 8); run(200);
    chk(cp_hi && !auto_active, "R5 locked manual high", {cp_hi, auto_active}, 2);
    auto_en = 1; run(3);
    chk(!cp_hi && auto_active, "R5 locked auto low", {cp_hi, auto_active}, 1);
    cp_hi_req = 0; auto_en = 0; run(3);
    chk(!cp_hi && !auto_active, "R5 request low", {cp_hi, auto_active}, 0);
    cp_hi_req = 1; auto_en = 1;
    do_reset(2'b00, 9); run(200);
    chk(cp_hi && !auto_active, "R5 unlocked auto keeps high", {cp_hi, auto_active}, 2);
    auto_en = 0;

    // R7 config change clears lock, then relocks
    do_reset(2'b00, 8); run(200);
    chk(lock_flag, "R7 pre-change lock", lock_flag, 1);
    ref_sel = 2'b01; div_val = 10; run(3);
    chk(!lock_flag, "R7 lock cleared", lock_flag, 0);
    run(200);
    chk(lock_flag, "R7 relock", lock_flag, 1);

    // R10 lost feedback
    vco_tick = 0; run(RB + 10);
    chk(!lock_flag && test_out, "R10 lock lost", lock_flag, 0);
    vco_tick = 1;

    chk(n_overlap == 0, "R6 no double overlap", n_overlap, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule